// File: doc/BRIEF.md
# Bus Ownership Handoff Controller

This controller sits on the processor side of a shared, multiplexed address/data system bus. It decides at every clock whether the processor or an outside agent owns the bus. While the processor owns it (master state), processor requests are granted one transaction at a time. When the agent pulls its active-low request line low, the controller waits for any processor transaction still in flight to finish. It then drives a one-cycle active-low release strobe and hands the bus over (slave state).

In slave state the agent may run any number of request cycles, back to back. Ownership comes back to the processor only after the agent lets go of its request line. The return passes through a turnaround window of `TURN_CYCLES` clocks (one by default), during which nobody is granted.

The processor side can also park the interface in slave state on its own. In that case an agent request is serviced at once, with no release strobe. The data path, command decoding and data beats are handled elsewhere. The bus-width mode input is carried only so that the controller provably ignores it.

Top module: `bus_handoff_ctrl`

## Requirements
- R1: After reset `own_state` is MASTER_IDLE (encoding 0), `release_n` is 1, and `cpu_grant` and `ext_ack` are 0. The state encodings are: MASTER_IDLE=0, MASTER_BUSY=1, RELEASE=2, SLAVE=3, RETURN=4.
- R2: In MASTER_IDLE with `ext_req_n`=1 and `park`=0, a sampled `cpu_req`=1 moves the state to MASTER_BUSY at the next cycle. `cpu_grant` is 1 exactly while the state is MASTER_BUSY. A sampled `txn_done`=1 in MASTER_BUSY with `ext_req_n`=1 returns the state to MASTER_IDLE.
- R3: An external request seen during MASTER_BUSY does not end the transaction. The state stays MASTER_BUSY until `txn_done` is sampled at 1, and only then moves to RELEASE. `release_n` is never 0 while a processor transaction is incomplete.
- R4: `release_n` is 0 for exactly one cycle, namely the cycle in which the state is RELEASE, and RELEASE is always followed by SLAVE.
- R5: In MASTER_IDLE, `park`=1 with `ext_req_n`=1 moves the state straight to SLAVE with no release strobe. An external request arriving while parked is serviced in that same slave period.
- R6: SLAVE is held while `ext_req_n`=0 or `park`=1, with no further release strobe. `ext_ack` equals `ext_cycle_valid` while in SLAVE and is 0 in every other state.
- R7: A single external request (`ext_req_n` low when sampled in MASTER_IDLE, then deasserted two cycles after the release cycle) is serviced once in SLAVE and followed by the return to master.
- R8: SLAVE exits only to RETURN. RETURN lasts `TURN_CYCLES` cycles with `cpu_grant`=0 and then gives MASTER_IDLE.
- R9: When `cpu_req` and an external request are sampled together in MASTER_IDLE, the external request wins: the state goes to RELEASE. A still-pending `cpu_req` is granted only after the state is back in MASTER_IDLE.
- R10: The `bus_wide` mode input has no effect on any output or state transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request pending |
| txn_done | input | 1 | Current processor transaction completes this cycle |
| ext_req_n | input | 1 | Active-low external request from the agent |
| ext_cycle_valid | input | 1 | Agent presents a valid request cycle |
| park | input | 1 | Processor voluntarily places the interface in slave state |
| bus_wide | input | 1 | Bus width mode (1 = wide); no effect on handoff |
| release_n | output | 1 | Active-low one-cycle release strobe |
| own_state | output | 3 | Current ownership state encoding |
| cpu_grant | output | 1 | Processor owns the bus for a transaction |
| ext_ack | output | 1 | External request cycle accepted in slave state |

## Verification
The bench builds the controller with `TURN_CYCLES`=2. This makes the turnaround counter take a real step before it reaches its terminal count, so an off-by-one in the RETURN window shows up as a state mismatch. Directed sequences drive the single-request timing, long request series, parking, a request that arrives in the middle of a transaction, and same-cycle contention. A long stretch of random inputs with `bus_wide` toggling then reaches mixed orderings, such as park and request overlapping, or `txn_done` arriving together with an external request.

// File: rtl/handoff_pkg.sv
package handoff_pkg;

  typedef enum logic [2:0] {
    MASTER_IDLE = 3'd0,
    MASTER_BUSY = 3'd1,
    RELEASE     = 3'd2,
    SLAVE       = 3'd3,
    RETURN      = 3'd4
  } own_e;

endpackage

// File: rtl/handoff_fsm.sv
module handoff_fsm
  import handoff_pkg::*;
#(
  parameter int TURN_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic txn_done,
  input  logic ext_req_n,
  input  logic park,
  output own_e state
);

  localparam int TW = (TURN_CYCLES < 2) ? 1 : $clog2(TURN_CYCLES);
  localparam logic [TW-1:0] TURN_LAST = TW'(TURN_CYCLES - 1);

  // named events brought out for the assertions
  logic ext_pending;
  logic txn_open;
  logic slave_exit;
  logic turn_end;
  logic [TW-1:0] turn_cnt;
  own_e state_nx;

  assign ext_pending = !ext_req_n;
  assign txn_open    = (state == MASTER_BUSY) && !txn_done;
  assign slave_exit  = ext_req_n && !park;
  assign turn_end    = (turn_cnt == TURN_LAST);

  function automatic own_e next_own(own_e cur, logic creq, logic done,
                                    logic xreq, logic prk, logic tend);
    own_e n;
    n = cur;
    unique case (cur)
      MASTER_IDLE: begin
        if (xreq)      n = RELEASE;
        else if (prk)  n = SLAVE;
        else if (creq) n = MASTER_BUSY;
      end
      MASTER_BUSY: if (done) n = xreq ? RELEASE : MASTER_IDLE;
      RELEASE:     n = SLAVE;
      SLAVE:       if (!xreq && !prk) n = RETURN;
      RETURN:      if (tend) n = MASTER_IDLE;
      default:     n = MASTER_IDLE;
    endcase
    return n;
  endfunction

  assign state_nx = next_own(state, cpu_req, txn_done, ext_pending, park, turn_end);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= MASTER_IDLE;
    else        state <= state_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || state != RETURN) turn_cnt <= '0;
    else if (!turn_end)            turn_cnt <= turn_cnt + 1'b1;
  end

  // R3: an open processor transaction is never cut short by a release
  a_r3_no_release_mid_txn: assert property (@(posedge clk) disable iff (!rst_n)
    txn_open |=> (state == MASTER_BUSY));

  // R4: release is one cycle and leads to slave ownership
  a_r4_release_to_slave: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RELEASE) |=> (state == SLAVE));

  // R6: a held request keeps slave ownership
  a_r6_slave_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SLAVE && ext_pending) |=> (state == SLAVE));

  // R8: slave leaves only through the turnaround window
  a_r8_slave_exit_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SLAVE && slave_exit) |=> (state == RETURN));

  // R8: turnaround stays until its counter reaches the last count
  a_r8_turn_length: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RETURN && !turn_end) |=> (state == RETURN));

  // R9: contention in idle goes to the external side
  a_r9_ext_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MASTER_IDLE && ext_pending && cpu_req) |=> (state == RELEASE));

endmodule

// File: rtl/handoff_outputs.sv
module handoff_outputs
  import handoff_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  own_e state,
  input  logic ext_cycle_valid,
  output logic release_n,
  output logic cpu_grant,
  output logic ext_ack
);

  assign release_n = (state != RELEASE);
  assign cpu_grant = (state == MASTER_BUSY);
  assign ext_ack   = (state == SLAVE) && ext_cycle_valid;

  // R4: the strobe never lasts two cycles
  a_r4_release_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !release_n |=> release_n);

  // R8: no processor grant right after leaving slave ownership
  a_r8_no_grant_after_slave: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SLAVE) |=> !cpu_grant);

endmodule

// File: rtl/bus_handoff_ctrl.sv
module bus_handoff_ctrl
  import handoff_pkg::*;
#(
  parameter int TURN_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req,
  input  logic       txn_done,
  input  logic       ext_req_n,
  input  logic       ext_cycle_valid,
  input  logic       park,
  input  logic       bus_wide,
  output logic       release_n,
  output logic [2:0] own_state,
  output logic       cpu_grant,
  output logic       ext_ack
);

  own_e state;

  handoff_fsm #(.TURN_CYCLES(TURN_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .txn_done  (txn_done),
    .ext_req_n (ext_req_n),
    .park      (park),
    .state     (state)
  );

  handoff_outputs u_out (
    .clk             (clk),
    .rst_n           (rst_n),
    .state           (state),
    .ext_cycle_valid (ext_cycle_valid),
    .release_n       (release_n),
    .cpu_grant       (cpu_grant),
    .ext_ack         (ext_ack)
  );

  assign own_state = state;

  // R10: the width mode is accepted as a defined level but steers nothing
  a_r10_mode_defined: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(bus_wide));

  // R1: reset leaves the controller idle in master state
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (own_state == 3'd0));

endmodule

// File: tb/tb_bus_handoff_ctrl.sv
module tb_bus_handoff_ctrl;

  localparam int TC = 2;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, txn_done = 0, ext_req_n = 1, ext_cycle_valid = 0, park = 0, bus_wide = 0;
  logic release_n, cpu_grant, ext_ack;
  logic [2:0] own_state;

  int vectors = 0, miscompares = 0;
  int ms = 0, mt = 0;   // model: ownership state and turnaround count
  bit finished = 0;

  always #2 clk = ~clk;

  bus_handoff_ctrl #(.TURN_CYCLES(TC)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .txn_done(txn_done),
    .ext_req_n(ext_req_n), .ext_cycle_valid(ext_cycle_valid), .park(park),
    .bus_wide(bus_wide), .release_n(release_n), .own_state(own_state),
    .cpu_grant(cpu_grant), .ext_ack(ext_ack)
  );

  task automatic compare(input string tag);
    logic [2:0] e_st;
    logic e_rel, e_gnt, e_ack;
    e_st  = 3'(ms);
    e_rel = (ms != 2);
    e_gnt = (ms == 1);
    e_ack = (ms == 3) && ext_cycle_valid;
    vectors++;
    if (own_state !== e_st || release_n !== e_rel || cpu_grant !== e_gnt || ext_ack !== e_ack) begin
      miscompares++;
      $display("FAIL %s: state=%0d rel_n=%b grant=%b ack=%b expected state=%0d rel_n=%b grant=%b ack=%b",
               tag, own_state, release_n, cpu_grant, ext_ack, e_st, e_rel, e_gnt, e_ack);
    end
  endtask

  // reference: ownership rules restated from the requirements
  task automatic model_step();
    case (ms)
      0: begin
        if (!ext_req_n)   ms = 2;
        else if (park)    ms = 3;
        else if (cpu_req) ms = 1;
      end
      1: if (txn_done) ms = ext_req_n ? 0 : 2;
      2: ms = 3;
      3: if (ext_req_n && !park) begin ms = 4; mt = 0; end
      4: if (mt == TC - 1) ms = 0; else mt++;
      default: ms = 0;
    endcase
  endtask

  task automatic cyc(input bit creq, input bit done, input bit xreq_n, input bit xval,
                     input bit prk, input string tag);
    cpu_req = creq; txn_done = done; ext_req_n = xreq_n; ext_cycle_valid = xval; park = prk;
    #1;
    compare(tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: state=%0d expected run to end", own_state);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; compare("R1 reset");
    @(posedge clk); rst_n = 1; @(negedge clk);
    compare("R1 after reset");

    // R2: processor transaction, done after three cycles
    cyc(1, 0, 1, 0, 0, "R2 request");
    cyc(1, 0, 1, 0, 0, "R2 busy");
    cyc(0, 0, 1, 0, 0, "R2 busy");
    cyc(0, 1, 1, 0, 0, "R2 done");
    cyc(0, 0, 1, 0, 0, "R2 idle");

    // R7: single external request, deasserted 2 cycles after release
    cyc(0, 0, 0, 0, 0, "R7 sample");
    cyc(0, 0, 0, 0, 0, "R7 release");
    cyc(0, 0, 0, 1, 0, "R7 slave cycle");
    cyc(0, 0, 1, 0, 0, "R7 drop");
    for (int i = 0; i < TC + 1; i++) cyc(0, 0, 1, 0, 0, "R8 turnaround");

    // R3: request arrives mid transaction
    cyc(1, 0, 1, 0, 0, "R3 start");
    cyc(0, 0, 0, 0, 0, "R3 busy with ext");
    cyc(0, 0, 0, 0, 0, "R3 still busy");
    cyc(0, 1, 0, 0, 0, "R3 done");
    cyc(0, 0, 0, 0, 0, "R4 release");
    // R6: series of external cycles, no re-release
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, i[0], 0, "R6 series");
    cyc(1, 0, 1, 1, 0, "R6 last");
    for (int i = 0; i < TC; i++) cyc(1, 0, 1, 0, 0, "R8 no grant");
    cyc(1, 0, 1, 0, 0, "R8 back idle");
    cyc(0, 1, 1, 0, 0, "R2 done");

    // R5: parking, then request serviced at once
    cyc(0, 0, 1, 0, 1, "R5 park");
    cyc(0, 0, 1, 1, 1, "R5 parked ack");
    cyc(0, 0, 0, 1, 1, "R5 ext while parked");
    cyc(0, 0, 0, 1, 0, "R5 ext held");
    cyc(0, 0, 1, 0, 0, "R5 leave");
    for (int i = 0; i < TC + 1; i++) cyc(0, 0, 1, 0, 0, "R8 turnaround");

    // R9: contention in idle
    cyc(1, 0, 0, 0, 0, "R9 both");
    cyc(1, 0, 0, 0, 0, "R9 release");
    cyc(1, 0, 1, 1, 0, "R9 slave");
    for (int i = 0; i < TC; i++) cyc(1, 0, 1, 0, 0, "R9 turnaround");
    cyc(1, 0, 1, 0, 0, "R9 idle pending");
    cyc(0, 1, 1, 0, 0, "R9 granted");
    cyc(0, 0, 1, 0, 0, "R9 idle");

    // R10: random traffic with the width mode toggling
    for (int i = 0; i < 3000; i++) begin
      bus_wide = 1'($urandom);
      cyc(1'($urandom), ($urandom % 4) == 0, ($urandom % 3) != 0, 1'($urandom),
          ($urandom % 8) == 0, "R10 random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule